// File: doc/BRIEF.md
# Shared Transform Accelerator Register Front End

This block is the bus-facing register file for a fixed-function transform engine that several processors share. A master first claims the engine by reading the lock word. It then fills a 32-word input buffer and issues a start command. Next it learns of completion, either by polling a flag word or, when the block is built in interrupt mode, from a level interrupt request. Finally it reads back a 32-word output buffer and writes the release command, which frees the engine for the next master.

The transform datapath itself is not part of the block. A placeholder core stands in for it: a fixed number of cycles (`LATENCY`) after a start is accepted, it copies every input word to the matching output word. The bus is a single-cycle, word-addressed port that carries byte offsets. The two low address bits are ignored. Read data is registered.

Top module: `xform_regs`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the lock, busy, completion and interrupt state, so `irq` is 0 and the flag word reads 0. Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R2: A read of byte offset 0 returns 1 while the engine is owned. A read that returns 0 claims ownership, so every later read returns 1 until the release.
- R3: A write of exactly the value 1 to byte offset 4 starts an operation only when the engine is owned and idle. Starting also clears any earlier completion and interrupt. Any other value, a start while unowned, and a start while an operation is running are all ignored.
- R4: Completion is recorded on the `LATENCY`-th clock edge after the edge that accepted the start. At that edge every output word takes the value of the input word with the same index.
- R5: In polled mode (`IRQ_MODE` = 0), byte offset 8 reads 0 while an operation runs and 1 once it has completed.
- R6: Byte offsets 64 to 188 hold the input words, word i at offset 64 + 4i. These words are write-only and read as 0. Writes to them while an operation runs are ignored.
- R7: Byte offsets 192 to 316 hold the output words, word i at offset 192 + 4i. These words are read-only, ignore writes, and keep their previous contents until the next completion.
- R8: In interrupt mode (`IRQ_MODE` = 1), `irq` rises on the edge that records completion and stays high until a write of 1 to offset 8 or a release. In this mode offset 8 reads 0. In polled mode `irq` stays 0 and a write to offset 8 has no effect.
- R9: A write of 1 to byte offset 12 clears completion, clears the interrupt and releases ownership. The write is ignored while an operation runs.
- R10: Reads of unmapped offsets (for example 16, and 320 or above) return 0. Writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; bits 1:0 are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level completion request (interrupt mode only) |

## Verification
The embedded properties check, on every cycle, the invariants that tie the control state together. A start can only begin from an owned state. Completion only follows a running operation, and the engine is never busy and complete at the same time. The interrupt never stands without a recorded completion, and ownership cannot be dropped while the engine runs. Only the bench scenarios can show the behaviours that depend on data and timing. These include the exact latency from start to `irq`, the input-to-output copy and the output hold between operations. They also include the claim-by-read lock sequence and the ignored commands (bad start values, starts and releases during a run, writes to read-only or unmapped words). Both completion modes are driven side by side with identical traffic.

// File: rtl/xform_regs.sv
module xform_regs #(
  parameter int DATA_W   = 32,
  parameter int N_WORDS  = 32,
  parameter int LATENCY  = 8,
  parameter int IRQ_MODE = 0,
  parameter int ADDR_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(N_WORDS);
  localparam int CNT_W  = $clog2(LATENCY + 1);
  localparam logic [WIDX_W-1:0] W_LOCK   = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_START  = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_FLAG   = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_UNLOCK = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] IN_LO    = WIDX_W'(16);
  localparam logic [WIDX_W-1:0] OUT_LO   = WIDX_W'(16 + N_WORDS);
  localparam logic [WIDX_W-1:0] OUT_HI   = WIDX_W'(16 + 2 * N_WORDS);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(LATENCY - 1);

  logic [DATA_W-1:0] in_words  [N_WORDS];
  logic [DATA_W-1:0] out_words [N_WORDS];
  logic              owned, busy, done, irq_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_val;

  wire [WIDX_W-1:0] widx   = bus_addr[ADDR_W-1:2];
  wire              rd     = bus_req & ~bus_we;
  wire              wr     = bus_req & bus_we;
  wire              wone   = (bus_wdata == DATA_W'(1));
  wire              is_in  = (widx >= IN_LO) && (widx < OUT_LO);
  wire              is_out = (widx >= OUT_LO) && (widx < OUT_HI);
  wire [WIDX_W-1:0] in_off  = widx - IN_LO;
  wire [WIDX_W-1:0] out_off = widx - OUT_LO;

  wire grab     = rd && widx == W_LOCK;
  wire start_ok = wr && widx == W_START && wone && owned && !busy;
  wire finish   = busy && cnt == CNT_LAST;
  wire clr_irq  = wr && widx == W_FLAG && wone && (IRQ_MODE != 0);
  wire release_ok = wr && widx == W_UNLOCK && wone && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      owned <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      irq_q <= 1'b0;
      cnt   <= '0;
    end else begin
      if (grab) owned <= 1'b1;
      if (clr_irq) irq_q <= 1'b0;
      if (release_ok) begin
        owned <= 1'b0;
        done  <= 1'b0;
        irq_q <= 1'b0;
      end
      if (start_ok) begin
        busy  <= 1'b1;
        cnt   <= '0;
        done  <= 1'b0;
        irq_q <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (finish) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          irq_q <= (IRQ_MODE != 0);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr && is_in && !busy) in_words[in_off[IDX_W-1:0]] <= bus_wdata;
    if (finish)
      for (int i = 0; i < N_WORDS; i++) out_words[i] <= in_words[i];
  end

  always_comb begin
    rd_val = '0;
    if (widx == W_LOCK)      rd_val = DATA_W'(owned);
    else if (widx == W_FLAG) rd_val = (IRQ_MODE != 0) ? '0 : DATA_W'(done);
    else if (is_out)         rd_val = out_words[out_off[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_val;
  end

  assign irq = irq_q;

  assert_start_owned_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(owned));
  assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);
  assert_owner_kept_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> owned);
endmodule

// File: tb/test_xform_regs.sv
module test_xform_regs;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 6;
  localparam int NW  = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_p, rd_i;
  logic        irq_p, irq_i;
  int unsigned cyc = 0;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_in [NW];
  logic [31:0] exp_out [NW];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xform_regs #(.LATENCY(LAT), .IRQ_MODE(0)) i_xform_regs (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_p), .irq(irq_p));
  xform_regs #(.LATENCY(LAT), .IRQ_MODE(1)) i_xform_regs_irq (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_i), .irq(irq_i));

  function automatic logic [31:0] flag_word(bit irq_mode, bit complete);
    return irq_mode ? 32'd0 : {31'd0, complete};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 9'(addr); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [31:0] dp, output logic [31:0] di);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 9'(addr);
    @(negedge clk);
    bus_req = 1'b0;
    dp = rd_p; di = rd_i;
  endtask

  task automatic wait_irq(int unsigned s);
    while (cyc < s + LAT - 1) @(negedge clk);
    if (cyc == s + LAT - 1) chk("R4", "irq before latency", {31'd0, irq_i}, 32'd0);
    while (cyc < s + LAT) @(negedge clk);
    chk("R4", "irq at latency", {31'd0, irq_i}, 32'd1);
    chk("R8", "polled irq stays low", {31'd0, irq_p}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] dp, di;
    int unsigned s;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "irq after reset", {31'd0, irq_i}, 32'd0);
    bus_read(8, dp, di);
    chk("R1", "flag after reset", dp, 32'd0);
    // R3: start while unowned ignored
    bus_write(4, 1);
    repeat (LAT + 2) @(negedge clk);
    bus_read(8, dp, di);
    chk("R3", "unowned start flag", dp, 32'd0);
    chk("R3", "unowned start irq", {31'd0, irq_i}, 32'd0);
    // R2: claim by read
    bus_read(0, dp, di);
    chk("R2", "first lock read", dp, 32'd0);
    chk("R2", "first lock read irq-mode", di, 32'd0);
    bus_read(0, dp, di);
    chk("R2", "second lock read", dp, 32'd1);
    // R3: wrong value ignored
    bus_write(4, 2);
    repeat (LAT + 2) @(negedge clk);
    bus_read(8, dp, di);
    chk("R3", "start value 2 ignored", dp, 32'd0);
    // R10: unmapped
    bus_write(16, 32'h55);
    bus_read(16, dp, di);
    chk("R10", "unmapped read 16", dp, 32'd0);
    bus_read(320, dp, di);
    chk("R10", "unmapped read 320", dp, 32'd0);
    bus_write(12, 1);

    for (int r = 0; r < 4; r++) begin
      bus_read(0, dp, di);
      chk("R2", "lock read in round", dp, 32'd0);
      for (int i = 0; i < NW; i++) begin
        exp_in[i] = $urandom;
        bus_write(64 + 4 * i, exp_in[i]);
      end
      bus_read(64 + 4 * (r % NW), dp, di);
      chk("R6", "input word reads 0", dp, 32'd0);
      bus_write(4, 1);
      s = cyc;
      bus_read(8, dp, di);
      chk("R5", "flag while running", dp, 32'd0);
      bus_write(64, ~exp_in[0]);
      if (r > 0) begin
        bus_read(192, dp, di);
        chk("R7", "output held while running", dp, exp_out[0]);
      end
      wait_irq(s);
      for (int i = 0; i < NW; i++) exp_out[i] = exp_in[i];
      bus_read(8, dp, di);
      chk("R5", "flag after completion", dp, flag_word(1'b0, 1'b1));
      chk("R8", "flag word in irq mode", di, flag_word(1'b1, 1'b1));
      for (int i = 0; i < NW; i++) begin
        bus_read(192 + 4 * i, dp, di);
        chk("R4", "output word polled", dp, exp_out[i]);
        chk("R4", "output word irq", di, exp_out[i]);
      end
      bus_write(192 + 4 * r, $urandom);
      bus_read(192 + 4 * r, dp, di);
      chk("R7", "output ignores write", dp, exp_out[r]);
      if (r % 2 == 0) begin
        bus_write(8, 1);
        chk("R8", "irq cleared at offset 8", {31'd0, irq_i}, 32'd0);
        bus_read(8, dp, di);
        chk("R8", "polled flag unaffected", dp, 32'd1);
      end
      bus_write(12, 1);
      chk("R9", "irq cleared by release", {31'd0, irq_i}, 32'd0);
      bus_read(8, dp, di);
      chk("R9", "flag cleared by release", dp, 32'd0);
    end

    // R3/R9: start and release during a run ignored
    bus_read(0, dp, di);
    bus_write(4, 1);
    s = cyc;
    bus_write(4, 1);
    bus_write(12, 1);
    bus_read(0, dp, di);
    chk("R9", "release while running ignored", dp, 32'd1);
    wait_irq(s);
    bus_read(192, dp, di);
    chk("R6", "input write while running ignored", dp, exp_in[0]);
    bus_write(12, 1);
    bus_read(0, dp, di);
    chk("R9", "lock free after release", dp, 32'd0);
    chk("R9", "lock free irq-mode", di, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule